// File: doc/BRIEF.md
# Byte-Loaded ROM Address Sequencer

This block is the command front end of a 4M x 8 read-only store. A host has no address bus to the store. It reaches it over one byte-wide data path and a few control inputs: an active-low chip enable, an active-low read strobe, an active-low write strobe and a three-bit register select. The host loads a 22-bit address pointer as three byte writes. It then reads bytes one after another, and the pointer steps forward by one each time the read strobe is released.

The control inputs are taken to be synchronous to `clk`. The block samples them on each rising clock edge and acts on the low-to-high transition of each strobe. The bidirectional host bus is split into `bus_i`, `bus_o` and the enable `bus_oe`, which drives the pad. The store is a behavioural model whose content is a fixed function of the address, so any location can be checked without loading a table. Select values with bit 2 set belong to other registers that are not part of this block. This block ignores them.

Top module: `cmd_rom_seq`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) the pointer is 0 and the byte-write position is the low byte. The first read returns the content of address 0.
- R2: A write strobe rising edge with `ce_n`=0 and `rsel[2]`=0 stores `bus_i` into the pointer. Successive writes fill bits 7:0, then 15:8, then 21:16, and `rsel[1:0]` has no effect.
- R3: The third write uses only `bus_i[5:0]`, and bits 7:6 of that byte are discarded.
- R4: While `ce_n`=0, `oe_n`=0 and `rsel[2]`=0, `bus_oe` is 1 and `bus_o` equals the content at the pointer. The content at address a is the XOR of a[7:0], a[15:8] and {2'b00,a[21:16]}. In every other case `bus_oe` is 0 and `bus_o` is 0.
- R5: Each read strobe rising edge with `ce_n`=0 and `rsel[2]`=0 adds one to the pointer, so the next read returns the following byte.
- R6: Incrementing from 22'h3FFFFF gives 22'h000000.
- R7: The write position returns to the low byte after the third write and after any qualified read. A partial load followed by a read restarts at the low byte.
- R8: While `ce_n`=1, strobes change neither the pointer nor the write position, and `bus_oe` is 0. `standby` follows `ce_n` one clock later.
- R9: While `rsel[2]`=1, strobes change neither the pointer nor the write position, and `bus_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| rsel | input | 3 | Register select; bit 2 low selects pointer/data |
| bus_i | input | 8 | Host bus, inbound |
| bus_o | output | 8 | Host bus, outbound data |
| bus_oe | output | 1 | Drive enable for the host bus |
| standby | output | 1 | Store in standby, registered copy of `ce_n` |

## Verification
A wrong pointer can only be seen through the read data. A faulty increment, wrap or field placement shows up as a wrong byte on the very next qualified read. Because the content is an XOR fold of all three fields, a misplaced byte in any field changes the value returned. A byte-position error stays hidden until the next write, so the bench follows each partial load with a read and a fresh full load. Leaks from gating (disabled chip, high select bit) show up as a driven bus at once, or as a shifted address on the first read after the chip is enabled again.

// File: rtl/cmd_rom_pkg.sv
package cmd_rom_pkg;
  localparam int unsigned DEF_ADDR_W = 22;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned RSEL_W     = 3;

  // number of byte fields needed to cover an address of width aw
  function automatic int unsigned field_count(input int unsigned aw, input int unsigned dw);
    return (aw + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic rise
);
  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= strb_n;
  end

  assign rise = !prev_n && strb_n;

  // a release cannot follow a release without a new assertion in between (R2, R5)
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/rom_model.sv
module rom_model #(
  parameter int unsigned ADDR_W = cmd_rom_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = cmd_rom_pkg::DEF_DATA_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  // content is the XOR fold of the address fields (R4)
  always_comb begin
    data = '0;
    for (int i = 0; i < ADDR_W; i++) data[i % DATA_W] = data[i % DATA_W] ^ addr[i];
  end
endmodule

// File: rtl/addr_loader.sv
module addr_loader #(
  parameter int unsigned ADDR_W = cmd_rom_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = cmd_rom_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned NFIELD = cmd_rom_pkg::field_count(ADDR_W, DATA_W);
  localparam int unsigned PTR_W  = (NFIELD > 1) ? $clog2(NFIELD) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NFIELD - 1);

  logic [PTR_W-1:0]  ptr, ptr_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    addr_nxt = addr;
    ptr_nxt  = ptr;
    if (wr_evt) begin
      for (int i = 0; i < ADDR_W; i++)
        if (PTR_W'(i / DATA_W) == ptr) addr_nxt[i] = wr_data[i % DATA_W];
      ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end else if (rd_evt) begin
      addr_nxt = addr + 1'b1;   // natural wrap to zero (R6)
      ptr_nxt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      ptr  <= '0;
    end else begin
      addr <= addr_nxt;
      ptr  <= ptr_nxt;
    end
  end

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !wr_evt) |=> addr == ADDR_W'($past(addr) + 1'b1));
  assert_ptr_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !wr_evt) |=> ptr == '0);
  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_evt && !wr_evt) |=> ($stable(addr) && $stable(ptr)));
endmodule

// File: rtl/cmd_rom_seq.sv
module cmd_rom_seq #(
  parameter int unsigned ADDR_W = cmd_rom_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = cmd_rom_pkg::DEF_DATA_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ce_n,
  input  logic                           oe_n,
  input  logic                           we_n,
  input  logic [cmd_rom_pkg::RSEL_W-1:0] rsel,
  input  logic [DATA_W-1:0]              bus_i,
  output logic [DATA_W-1:0]              bus_o,
  output logic                           bus_oe,
  output logic                           standby
);
  logic              we_rise, oe_rise, sel_ok, wr_evt, rd_evt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rom_q;

  strobe_rise u_we (.clk(clk), .rst_n(rst_n), .strb_n(we_n), .rise(we_rise));
  strobe_rise u_oe (.clk(clk), .rst_n(rst_n), .strb_n(oe_n), .rise(oe_rise));

  // select bit 2 low addresses the pointer/data path; low select bits ignored (R2, R9)
  assign sel_ok = !ce_n && !rsel[2];
  assign wr_evt = we_rise && sel_ok;
  assign rd_evt = oe_rise && sel_ok;

  addr_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .wr_data(bus_i), .addr(addr)
  );

  rom_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (.addr(addr), .data(rom_q));

  assign bus_oe = sel_ok && !oe_n;
  assign bus_o  = bus_oe ? rom_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) standby <= 1'b1;
    else        standby <= ce_n;
  end

  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_o == '0);
  assert_no_event_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !(wr_evt || rd_evt));
endmodule

// File: tb/sim_cmd_rom_seq.sv
`timescale 1ns/1ps
module sim_cmd_rom_seq;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [2:0] rsel = 3'b000;
  logic [7:0] bus_i = 8'h00, bus_o;
  logic bus_oe, standby;
  int ncmp = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  cmd_rom_seq u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
                  .rsel(rsel), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
                  .standby(standby));

  // op: 1 = write, 2 = read; {op[1:0], rsel[2:0], data[7:0], expect[7:0]}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 3'b000, 8'h56, 8'h00}, // R2 low byte
    {2'd1, 3'b001, 8'h34, 8'h00}, // R2 mid byte, rsel[1:0] ignored
    {2'd1, 3'b010, 8'h12, 8'h00}, // R2 high byte
    {2'd2, 3'b000, 8'h00, 8'h70}, // R4 addr 123456
    {2'd2, 3'b011, 8'h00, 8'h71}, // R5 addr 123457
    {2'd2, 3'b000, 8'h00, 8'h7E}, // R5 addr 123458
    {2'd1, 3'b011, 8'hAB, 8'h00},
    {2'd1, 3'b000, 8'hCD, 8'h00},
    {2'd1, 3'b000, 8'hFF, 8'h00}, // R3 bits 7:6 dropped
    {2'd2, 3'b000, 8'h00, 8'h59}, // R3 addr 3FCDAB
    {2'd2, 3'b000, 8'h00, 8'h5E},
    {2'd1, 3'b000, 8'hFF, 8'h00},
    {2'd1, 3'b000, 8'hFF, 8'h00},
    {2'd1, 3'b000, 8'hFF, 8'h00},
    {2'd2, 3'b000, 8'h00, 8'h3F}, // R6 addr 3FFFFF
    {2'd2, 3'b000, 8'h00, 8'h00}, // R6 wrapped to 0
    {2'd2, 3'b000, 8'h00, 8'h01}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] rs, input logic [7:0] d);
    @(negedge clk); rsel = rs; bus_i = d; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // returns {bus_oe, bus_o} sampled while the strobe is low
  task automatic rd(input logic [2:0] rs, output logic [8:0] got);
    @(negedge clk); rsel = rs; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); got = {bus_oe, bus_o}; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    #(2.5 * 2 * 100000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [8:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus idle", {bus_oe, bus_o}, 9'h000);
    check("R8 standby", {8'h00, standby}, 9'h001);
    ce_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 standby low", {8'h00, standby}, 9'h000);
    rd(3'b000, g); check("R1 first read", g, 9'h100);   // addr 0 -> content 00
    rd(3'b000, g); check("R1 second read", g, 9'h101);

    // partial load, read, then full load: write position restarts (R7)
    wr(3'b000, 8'h10);
    rd(3'b000, g); check("R7 partial load read", g, {1'b1, 8'h10});

    // table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20:19] == 2'd1) wr(VEC[k][18:16], VEC[k][15:8]);
      else begin
        rd(VEC[k][18:16], g);
        check($sformatf("R4/R5 vector %0d", k), g, {1'b1, VEC[k][7:0]});
      end
    end

    // R7: pointer at low byte after reads; load 000020
    wr(3'b000, 8'h20); wr(3'b000, 8'h00); wr(3'b000, 8'h00);
    rd(3'b000, g); check("R7 restart at low byte", g, {1'b1, 8'h20});

    // R8: disabled chip ignores strobes and keeps bus released
    ce_n = 1'b1;
    wr(3'b000, 8'h77); wr(3'b000, 8'h77); wr(3'b000, 8'h77);
    rd(3'b000, g); check("R8 bus off when disabled", g, 9'h000);
    check("R8 standby high", {8'h00, standby}, 9'h001);
    ce_n = 1'b0;
    rd(3'b000, g); check("R8 pointer unchanged", g, {1'b1, 8'h21});

    // R9: select bit 2 high is ignored
    wr(3'b100, 8'h55); wr(3'b101, 8'h55); wr(3'b111, 8'h55);
    rd(3'b110, g); check("R9 bus off for rsel[2]", g, 9'h000);
    rd(3'b000, g); check("R9 pointer unchanged", g, {1'b1, 8'h22});

    // R1: asynchronous reset mid-run
    wr(3'b000, 8'h3C);
    #1 rst_n = 1'b0; #3 rst_n = 1'b1;
    rd(3'b000, g); check("R1 reset clears pointer", g, 9'h100);
    wr(3'b000, 8'h05); wr(3'b000, 8'h01); wr(3'b000, 8'h02);
    rd(3'b000, g); check("R1 write position cleared", g, {1'b1, 8'h06});

    done = 1;
    finish_run();
  end
endmodule